// File: doc/BRIEF.md
# Selectable Pin and Group Interrupt Unit

This block turns general-purpose pin activity into interrupt requests. It watches a flat vector of pin inputs, built from several ports of equal width. Eight request channels each pick one pin by index. A channel works in one of two modes. In edge mode it latches a qualified rising or falling transition into a sticky pending state, which stays set until a write-one-to-clear pulse. In level mode it simply follows the chosen pin at a programmed polarity.

Two group requests sit beside the channels. Each group has an enable mask and a polarity mask that span every pin. A mode bit chooses whether the group fires when any enabled pin is at its active level (OR) or only when all enabled pins are (AND).

Every pin passes through a two-flop synchroniser. A third register stage keeps the previous synchronised value, and edge detection compares the two. All configuration arrives on static input ports, and the requests leave on plain output wires.

Each channel is a two-state machine. CH_IDLE moves to CH_PEND on the transition EDGE_SEEN. CH_PEND moves back to CH_IDLE on the transition CLEARED, which happens when the clear bit is set and no new edge arrives in the same cycle. Both states move to CH_IDLE on the transition LEVEL_FORCE while the channel is in level mode.

Top module: `pin_irq_unit`

## Requirements
- R1: While reset is low and after its release, every channel is in CH_IDLE and the synchroniser stages hold zero. With all channels in edge mode with no edge enables, and with group enables at zero, every output is 0.
- R2: Channel n observes the pin whose index is `ch_sel_i[n*5 +: 5]`, with 32 pins where pin p is bit p of `pins_i`. No other pin affects that channel.
- R3: In edge mode (`ch_level_i[n]`=0), a 0-to-1 change on the selected pin with `ch_rise_en_i[n]`=1, or a 1-to-0 change with `ch_fall_en_i[n]`=1, raises `ch_irq_o[n]`. The pin is driven before clock edge k and the output is high after edge k+2. A change that its enable does not cover has no effect.
- R4: A pending edge request stays high until `ch_clr_i[n]` is 1 at a clock edge, and it reads 0 after that edge. If a qualified edge is detected at the same clock edge, the edge wins and the request stays high.
- R5: In level mode (`ch_level_i[n]`=1), `ch_irq_o[n]` equals 1 when the synchronised selected pin equals `ch_pol_i[n]`, after two clock edges, and nothing is latched. Being in level mode discards any pending edge state.
- R6: Changing a channel's pin selection does not by itself create an edge, even when the old and new pins differ in level.
- R7: Group g with `grp_and_i[g]`=0 drives `grp_irq_o[g]` to 1 when any pin p with enable bit `grp_en_i[g*32+p]`=1 has a synchronised value equal to `grp_pol_i[g*32+p]`. The result appears two clock edges after the pin change.
- R8: Group g with `grp_and_i[g]`=1 requests only when every enabled pin matches its polarity. A group with no enabled pins never requests, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 32 | Asynchronous pin levels, all ports concatenated |
| ch_sel_i | input | 40 | Pin index per channel, 5 bits each |
| ch_level_i | input | 8 | 1 = level mode, 0 = edge mode |
| ch_pol_i | input | 8 | Active level in level mode |
| ch_rise_en_i | input | 8 | Rising-edge enable in edge mode |
| ch_fall_en_i | input | 8 | Falling-edge enable in edge mode |
| ch_clr_i | input | 8 | Write-one-to-clear pulse for pending state |
| grp_en_i | input | 64 | Per-group pin enable mask, 32 bits per group |
| grp_pol_i | input | 64 | Per-group pin active level, 32 bits per group |
| grp_and_i | input | 2 | 1 = AND combine, 0 = OR combine |
| ch_irq_o | output | 8 | Channel interrupt requests |
| grp_irq_o | output | 2 | Group interrupt requests |

## Verification
The bench aims at a clear that arrives in the same cycle as a fresh edge. A design that gave the clear priority would lose that edge and leave the request low. It also switches a channel's pin selection between pins at different levels. A design that compared the old pin against the new one would report a phantom edge there. Random traffic moves channels in and out of level mode, so pending state that survived the switch would show up as a stray request. Groups with empty enable masks are tested in AND mode, where a naive all-match test would fire permanently.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } ch_state_e;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] cur_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw_i;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/pin_irq_chan.sv
module pin_irq_chan
    import pin_irq_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int SELW  = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] cur_i,
    input  logic [NPINS-1:0] prev_i,
    input  logic [SELW-1:0]  sel_i,
    input  logic             level_i,
    input  logic             pol_i,
    input  logic             rise_en_i,
    input  logic             fall_en_i,
    input  logic             clr_i,
    output logic             irq_o
);
    ch_state_e st_q, st_d;
    logic      in_range;
    logic      pin_now;
    logic      pin_old;
    logic      edge_hit;

    always_comb begin
        in_range = (int'(sel_i) < NPINS);
        pin_now  = in_range ? cur_i[sel_i]  : 1'b0;
        pin_old  = in_range ? prev_i[sel_i] : 1'b0;
        edge_hit = (rise_en_i &&  pin_now && !pin_old) ||
                   (fall_en_i && !pin_now &&  pin_old);
    end

    // next-state logic: EDGE_SEEN, CLEARED, LEVEL_FORCE
    always_comb begin
        st_d = st_q;
        if (level_i) begin
            st_d = CH_IDLE;
        end else begin
            unique case (st_q)
                CH_IDLE: if (edge_hit) st_d = CH_PEND;
                CH_PEND: if (clr_i && !edge_hit) st_d = CH_IDLE;
                default: st_d = CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        if (level_i) irq_o = (pin_now == pol_i);
        else         irq_o = (st_q == CH_PEND);
    end

    AST_PEND_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == CH_PEND) |-> $past(pin_now != pin_old)); // R3

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_i && st_q == CH_PEND && !clr_i) |=> (st_q == CH_PEND)); // R4

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_i && clr_i && !edge_hit) |=> (st_q == CH_IDLE)); // R4

    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        level_i |=> (st_q == CH_IDLE)); // R5
endmodule

// File: rtl/pin_irq_group.sv
module pin_irq_group #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] cur_i,
    input  logic [NPINS-1:0] en_i,
    input  logic [NPINS-1:0] pol_i,
    input  logic             and_mode_i,
    output logic             irq_o
);
    logic [NPINS-1:0] match;

    always_comb begin
        match = en_i & ~(cur_i ^ pol_i);
        if (en_i == '0)      irq_o = 1'b0;
        else if (and_mode_i) irq_o = (match == en_i);
        else                 irq_o = |match;
    end
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit #(
    parameter int NPORTS    = 4,
    parameter int PORT_PINS = 8,
    parameter int NCH       = 8,
    parameter int NGRP      = 2,
    localparam int NPINS    = NPORTS * PORT_PINS,
    localparam int SELW     = $clog2(NPINS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPINS-1:0]      pins_i,
    input  logic [NCH*SELW-1:0]   ch_sel_i,
    input  logic [NCH-1:0]        ch_level_i,
    input  logic [NCH-1:0]        ch_pol_i,
    input  logic [NCH-1:0]        ch_rise_en_i,
    input  logic [NCH-1:0]        ch_fall_en_i,
    input  logic [NCH-1:0]        ch_clr_i,
    input  logic [NGRP*NPINS-1:0] grp_en_i,
    input  logic [NGRP*NPINS-1:0] grp_pol_i,
    input  logic [NGRP-1:0]       grp_and_i,
    output logic [NCH-1:0]        ch_irq_o,
    output logic [NGRP-1:0]       grp_irq_o
);
    logic [NPINS-1:0] pin_cur;
    logic [NPINS-1:0] pin_prev;

    pin_irq_sync #(.WIDTH(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pins_i),
        .cur_o  (pin_cur),
        .prev_o (pin_prev)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pin_irq_chan #(.NPINS(NPINS), .SELW(SELW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cur_i     (pin_cur),
            .prev_i    (pin_prev),
            .sel_i     (ch_sel_i[c*SELW +: SELW]),
            .level_i   (ch_level_i[c]),
            .pol_i     (ch_pol_i[c]),
            .rise_en_i (ch_rise_en_i[c]),
            .fall_en_i (ch_fall_en_i[c]),
            .clr_i     (ch_clr_i[c]),
            .irq_o     (ch_irq_o[c])
        );
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        pin_irq_group #(.NPINS(NPINS)) u_grp (
            .cur_i      (pin_cur),
            .en_i       (grp_en_i[g*NPINS +: NPINS]),
            .pol_i      (grp_pol_i[g*NPINS +: NPINS]),
            .and_mode_i (grp_and_i[g]),
            .irq_o      (grp_irq_o[g])
        );

        AST_GRP_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_en_i[g*NPINS +: NPINS] == '0) |-> !grp_irq_o[g]); // R8
    end
endmodule

// File: tb/test_pin_irq_unit.sv
`timescale 1ns/1ps
module test_pin_irq_unit;
    localparam int NP = 32;
    localparam int NC = 8;
    localparam int NG = 2;
    localparam int SW = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NP-1:0]  pins = '0;
    logic [NC*SW-1:0] sel = '0;
    logic [NC-1:0]  lvl = '0, pol = '0, ren = '0, fen = '0, clr = '0;
    logic [NG*NP-1:0] gen = '0, gpol = '0;
    logic [NG-1:0]  gand = '0;
    logic [NC-1:0]  ch_irq;
    logic [NG-1:0]  grp_irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pin_irq_unit i_pin_irq_unit (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .ch_sel_i(sel),
        .ch_level_i(lvl), .ch_pol_i(pol), .ch_rise_en_i(ren),
        .ch_fall_en_i(fen), .ch_clr_i(clr), .grp_en_i(gen),
        .grp_pol_i(gpol), .grp_and_i(gand),
        .ch_irq_o(ch_irq), .grp_irq_o(grp_irq)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: history of sampled pin vectors plus pending bits
    bit [NP-1:0] hist[$] = '{0, 0, 0};
    bit          pend[NC];

    function automatic int selof(int c);
        return int'(sel[c*SW +: SW]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{0, 0, 0};
            foreach (pend[c]) pend[c] = 0;
        end else begin
            for (int c = 0; c < NC; c++) begin
                bit now_v, old_v, hit;
                now_v = hist[1][selof(c)];
                old_v = hist[2][selof(c)];
                hit = (ren[c] && now_v && !old_v) || (fen[c] && !now_v && old_v);
                if (lvl[c]) pend[c] = 0;
                else if (hit) pend[c] = 1;
                else if (clr[c]) pend[c] = 0;
            end
            hist.push_front(pins);
            void'(hist.pop_back());
        end
        #1;
        begin
            logic [NC-1:0] ech;
            logic [NG-1:0] egr;
            string tg;
            tg = "R3";
            for (int c = 0; c < NC; c++) begin
                ech[c] = lvl[c] ? (hist[1][selof(c)] == pol[c]) : pend[c];
                if (ech[c] != ch_irq[c] && lvl[c]) tg = "R5";
            end
            chk(ech === ch_irq, tg, 32'(ch_irq), 32'(ech));
            tg = "R7";
            for (int g = 0; g < NG; g++) begin
                int nen, nm;
                nen = 0; nm = 0;
                for (int p = 0; p < NP; p++) begin
                    if (gen[g*NP+p]) begin
                        nen++;
                        if (hist[1][p] == gpol[g*NP+p]) nm++;
                    end
                end
                egr[g] = (nen == 0) ? 1'b0 : (gand[g] ? (nm == nen) : (nm > 0));
                if (egr[g] != grp_irq[g] && gand[g]) tg = "R8";
            end
            chk(egr === grp_irq, tg, 32'(grp_irq), 32'(egr));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setsel(input int c, input int p);
        sel[c*SW +: SW] = SW'(p);
    endtask

    initial begin
        #(200000 * 4);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        cyc(3);
        chk(ch_irq == '0 && grp_irq == '0, "R1", 32'({ch_irq, grp_irq}), 32'd0);
        rst_n = 1'b1;
        cyc(3);
        chk(ch_irq == '0 && grp_irq == '0, "R1", 32'({ch_irq, grp_irq}), 32'd0);

        // channel setup
        setsel(0, 3);  ren[0] = 1;
        setsel(1, 17); fen[1] = 1;
        setsel(2, 31); lvl[2] = 1; pol[2] = 1;
        setsel(5, 1);  ren[5] = 1; fen[5] = 1;
        pins = 32'h0002_0004; // pin17=1, pin2=1
        cyc(5);
        clr = '1; cyc(1); clr = '0; cyc(1);

        // R3 rising on ch0
        pins[3] = 1'b1; cyc(3);
        chk(ch_irq[0] == 1'b1, "R3", 32'(ch_irq[0]), 32'd1);
        // R2 falling on pin17 only touches ch1
        pins[17] = 1'b0; cyc(3);
        chk(ch_irq[1] == 1'b1, "R2", 32'(ch_irq[1]), 32'd1);
        // R4 sticky
        pins[3] = 1'b0; cyc(8);
        chk(ch_irq[0] == 1'b1, "R4", 32'(ch_irq[0]), 32'd1);
        clr[0] = 1'b1; cyc(1); clr[0] = 1'b0;
        chk(ch_irq[0] == 1'b0, "R4", 32'(ch_irq[0]), 32'd0);
        // R4 clear coinciding with new edge
        cyc(3);
        pins[3] = 1'b1; cyc(2);
        clr[0] = 1'b1; cyc(1); clr[0] = 1'b0;
        chk(ch_irq[0] == 1'b1, "R4", 32'(ch_irq[0]), 32'd1);
        // R5 level follows pin without latching
        pins[31] = 1'b1; cyc(2);
        chk(ch_irq[2] == 1'b1, "R5", 32'(ch_irq[2]), 32'd1);
        pins[31] = 1'b0; cyc(2);
        chk(ch_irq[2] == 1'b0, "R5", 32'(ch_irq[2]), 32'd0);
        // R6 selection switch pin1(0) -> pin2(1) makes no edge
        clr[5] = 1'b1; cyc(1); clr[5] = 1'b0; cyc(2);
        setsel(5, 2); cyc(6);
        chk(ch_irq[5] == 1'b0, "R6", 32'(ch_irq[5]), 32'd0);
        // R7 OR group, R8 AND group and empty group
        gen[0*NP +: NP] = 32'h30; gpol[0*NP +: NP] = 32'h30;
        gen[1*NP +: NP] = 32'h30; gpol[1*NP +: NP] = 32'h30; gand[1] = 1'b1;
        pins[4] = 1'b0; pins[5] = 1'b1; cyc(2);
        chk(grp_irq[0] == 1'b1, "R7", 32'(grp_irq[0]), 32'd1);
        chk(grp_irq[1] == 1'b0, "R8", 32'(grp_irq[1]), 32'd0);
        pins[4] = 1'b1; cyc(2);
        chk(grp_irq[1] == 1'b1, "R8", 32'(grp_irq[1]), 32'd1);
        gen[1*NP +: NP] = '0; pins = '1; cyc(2);
        chk(grp_irq[1] == 1'b0, "R8", 32'(grp_irq[1]), 32'd0);

        // random traffic, continuously compared against the model
        for (int i = 0; i < 3000; i++) begin
            if (i % 97 == 0) begin
                for (int c = 0; c < NC; c++) setsel(c, int'($urandom_range(0, NP-1)));
                lvl = NC'($urandom) & NC'($urandom);
                pol = NC'($urandom);
                ren = NC'($urandom);
                fen = NC'($urandom);
                gand = NG'($urandom);
                for (int g = 0; g < NG; g++) begin
                    gen[g*NP +: NP] = (i % 2 == 0) ? ($urandom & $urandom & $urandom) : '0;
                    gen[g*NP + int'($urandom_range(0, NP-1))] = 1'b1;
                    gpol[g*NP +: NP] = $urandom;
                end
            end
            pins = pins ^ ($urandom & $urandom & $urandom);
            clr = NC'($urandom & $urandom & $urandom);
            cyc(1);
        end
        clr = '0;
        cyc(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule